// File: doc/BRIEF.md
# Periodic Sine/Cosine Sample Generator

This block produces one sinusoid sample for each accepted sample strobe. An integer sample index k runs from 0 to p-1 and then wraps, where the period length p is set by configuration and need not be a power of two. A phase offset o, given in samples with half-sample resolution, is added to k. The sum (k+o) is reduced modulo p and turned into a normalized phase (k+o)/p by a sequential divider. That phase addresses a quarter-wave amplitude table, and the block interpolates linearly between neighbouring entries. Sine and cosine come from the same table through quadrant folding. Cosine is the sine with the phase advanced by a quarter period.

The period p and the offset are worked out outside the block from the tone frequency and the sample time. For example, a 20 kHz tone at 1 MHz gives p = 50, and a quarter-period shift is 12.5 samples. Period, offset and channel selection are captured only while reset is asserted. Each accepted strobe produces a one-cycle valid pulse a fixed number of cycles later, carrying 16-bit signed two's complement samples.

Top module: `sg_top`

## Requirements
- R1: On the first strobe accepted after reset, the block uses k = 0, so the first sample equals 32767·sin(2π·o/p).
- R2: k increases by one for every accepted strobe and returns from p-1 to 0. The sample after the wrap again uses k = 0.
- R3: When enabled, sin_o is within 6 LSB of 32767·sin(2π(k+o)/p).
- R4: When enabled, cos_o is within 6 LSB of 32767·cos(2π(k+o)/p).
- R5: The value on offset_h is 2·o, so its bit 0 is a half sample. It must be below 2p, and the angle argument (k+o) is reduced modulo p.
- R6: valid_o is high for exactly one cycle, following the 17th rising edge after the edge that accepted the strobe.
- R7: A strobe arriving while a sample is still in computation is ignored. It does not advance k and produces no valid pulse. A strobe held high continuously is therefore accepted once every 17 cycles.
- R8: sel encoding: 2'b01 gives sine only, 2'b10 gives cosine only, and 2'b00 or 2'b11 gives both. An output that is not selected reads 0 when valid is high.
- R9: At exact quarter-period angles the outputs are exactly 0, +32767 (0x7FFF) or -32767 (0x8001). The value 0x8000 is never produced.
- R10: While reset is asserted, valid_o, sin_o and cos_o are 0 and k is cleared. period, offset_h and sel are sampled only during reset, so changing them afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; configuration is captured while high |
| smp_en | input | 1 | Sample strobe |
| period | input | PER_W (16) | Samples per period p, at least 1 |
| offset_h | input | PER_W+1 (17) | Phase offset in half samples (2·o), below 2p |
| sel | input | 2 | Channel selection |
| sin_o | output | OUT_W (16) | Signed sine sample |
| cos_o | output | OUT_W (16) | Signed cosine sample |
| valid_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
The embedded assertions check on every cycle the following properties:
- The index stays below p.
- The reduced numerator stays below 2p.
- The index moves only on an accepted strobe.
- valid is a single-cycle pulse that follows the divider's completion.
- A deselected channel reads zero.
- The most negative code never appears.

Only the bench's scenarios can show the rest:
- The numerical accuracy against a real-valued sine and cosine.
- The exact 17-cycle latency.
- The wrap at non-power-of-two periods.
- Half-sample offsets.
- That configuration changes after reset are ignored.

// File: rtl/sg_pkg.sv
package sg_pkg;

  // channel selection decode: 2'b01 sine only, 2'b10 cosine only, else both
  function automatic logic sel_has_sin(input logic [1:0] s);
    return s != 2'b10;
  endfunction

  function automatic logic sel_has_cos(input logic [1:0] s);
    return s != 2'b01;
  endfunction

endpackage

// File: rtl/sg_index.sv
module sg_index #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [PER_W-1:0] per,
  input  logic [PER_W:0]   ofs2,
  output logic [PER_W-1:0] k,
  output logic [PER_W+1:0] num,
  output logic [PER_W+1:0] den
);
  localparam int NW = PER_W + 2;

  logic [NW-1:0] raw_sum;

  // numerator and denominator are both in half-sample units: (2k + 2o) / 2p
  function automatic logic [NW-1:0] wrap_once(input logic [NW-1:0] v, input logic [NW-1:0] lim);
    return (v >= lim) ? v - lim : v;
  endfunction

  assign den     = {1'b0, per, 1'b0};
  assign raw_sum = {1'b0, k, 1'b0} + {1'b0, ofs2};
  assign num     = wrap_once(raw_sum, den);

  always_ff @(posedge clk) begin
    if (rst) begin
      k <= '0;
    end else if (step) begin
      k <= (k == per - 1'b1) ? '0 : k + 1'b1;
    end
  end

  // R2: index always within 0..p-1
  a_r2_k_in_range: assert property (@(posedge clk) disable iff (rst) k < per);
  // R5: the reduced argument stays below one period
  a_r5_num_below_den: assert property (@(posedge clk) disable iff (rst) num < den);

endmodule

// File: rtl/sg_divider.sv
module sg_divider #(
  parameter int NUM_W = 18,
  parameter int Q_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [NUM_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quo
);
  localparam int CNT_W = $clog2(Q_W) + 1;

  logic [NUM_W-1:0] rem_q;
  logic [NUM_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NUM_W:0]   rem_nxt;
  logic             q_bit;

  // one restoring step: shift remainder, subtract divisor when it fits
  function automatic logic [NUM_W:0] div_step(input logic [NUM_W-1:0] r, input logic [NUM_W-1:0] d);
    logic [NUM_W:0] sh;
    sh = {r, 1'b0};
    if (sh >= {1'b0, d}) return {1'b1, NUM_W'(sh - {1'b0, d})};
    return {1'b0, NUM_W'(sh)};
  endfunction

  assign {q_bit, rem_nxt[NUM_W-1:0]} = div_step(rem_q, den_q);
  assign rem_nxt[NUM_W] = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      quo   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        cnt_q <= '0;
        rem_q <= num;
        den_q <= den;
        quo   <= '0;
      end else if (busy) begin
        rem_q <= rem_nxt[NUM_W-1:0];
        quo   <= {quo[Q_W-2:0], q_bit};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(Q_W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6: completion only directly after the last iteration
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

endmodule

// File: rtl/sg_quarter_lut.sv
module sg_quarter_lut #(
  parameter int OUT_W  = 16,
  parameter int TBL_AW = 8,
  parameter int FR_W   = 6
) (
  input  logic [TBL_AW+FR_W+1:0] phase,
  output logic [OUT_W-1:0]       val
);
  localparam int  N       = 1 << TBL_AW;
  localparam int  POS_W   = TBL_AW + FR_W;
  localparam int  PW      = OUT_W + FR_W;
  localparam int  AMP     = (1 << (OUT_W - 1)) - 1;
  localparam real HALF_PI = 1.5707963267948966;

  logic [OUT_W-1:0] tbl [0:N];

  // quarter-wave table with its end point, N+1 entries, computed at elaboration
  for (genvar i = 0; i <= N; i++) begin : g_tbl
    localparam real ARG = HALF_PI * real'(i) / real'(N);
    localparam int  V   = $rtoi($floor($sin(ARG) * real'(AMP) + 0.5));
    assign tbl[i] = OUT_W'(V);
  end

  logic [1:0]        quad;
  logic [POS_W-1:0]  pos;
  logic [POS_W:0]    mir;
  logic [TBL_AW:0]   idx, idx_n;
  logic [FR_W-1:0]   fr;
  logic [OUT_W-1:0]  base, diff, mag;
  logic [PW-1:0]     prod;

  assign quad  = phase[POS_W+1:POS_W];
  assign pos   = phase[POS_W-1:0];
  // odd quadrants run the table backwards
  assign mir   = quad[0] ? ({1'b1, {POS_W{1'b0}}} - {1'b0, pos}) : {1'b0, pos};
  assign idx   = mir[POS_W:FR_W];
  assign fr    = mir[FR_W-1:0];
  assign idx_n = (idx == (TBL_AW+1)'(N)) ? idx : idx + 1'b1;
  assign base  = tbl[idx];
  assign diff  = tbl[idx_n] - base;
  assign prod  = PW'(diff) * PW'(fr);
  assign mag   = base + OUT_W'(prod >> FR_W);
  // lower half-wave is the negated magnitude
  assign val   = quad[1] ? (~mag + 1'b1) : mag;

endmodule

// File: rtl/sg_top.sv
module sg_top #(
  parameter int OUT_W  = 16,
  parameter int PER_W  = 16,
  parameter int TBL_AW = 8,
  parameter int FR_W   = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_en,
  input  logic [PER_W-1:0]        period,
  input  logic [PER_W:0]          offset_h,
  input  logic [1:0]              sel,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o,
  output logic                    valid_o
);
  import sg_pkg::*;

  localparam int PH_W  = TBL_AW + FR_W + 2;
  localparam int NUM_W = PER_W + 2;

  logic [PER_W-1:0] per_q;
  logic [PER_W:0]   ofs_q;
  logic [1:0]       sel_q;
  logic             accept, busy, done;
  logic [PER_W-1:0] k;
  logic [NUM_W-1:0] num, den;
  logic [PH_W-1:0]  quo;
  logic [OUT_W-1:0] lut_val [2];
  logic [1:0]       ch_on;

  // configuration is only sampled while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= period;
      ofs_q <= offset_h;
      sel_q <= sel;
    end
  end

  assign accept   = smp_en && !busy;
  assign ch_on[0] = sel_has_sin(sel_q);
  assign ch_on[1] = sel_has_cos(sel_q);

  sg_index #(.PER_W(PER_W)) u_index (
    .clk(clk), .rst(rst), .step(accept), .per(per_q), .ofs2(ofs_q),
    .k(k), .num(num), .den(den)
  );

  sg_divider #(.NUM_W(NUM_W), .Q_W(PH_W)) u_div (
    .clk(clk), .rst(rst), .start(accept), .num(num), .den(den),
    .busy(busy), .done(done), .quo(quo)
  );

  // channel 0 sine, channel 1 cosine (phase advanced by a quarter turn)
  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [PH_W-1:0] ph;
    assign ph = quo + (PH_W'(c) << (PH_W - 2));
    sg_quarter_lut #(.OUT_W(OUT_W), .TBL_AW(TBL_AW), .FR_W(FR_W)) u_lut (
      .phase(ph), .val(lut_val[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_o   <= '0;
      cos_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= done;
      if (done) begin
        sin_o <= ch_on[0] ? lut_val[0] : '0;
        cos_o <= ch_on[1] ? lut_val[1] : '0;
      end
    end
  end

  // R6: valid is a single-cycle pulse that follows divider completion
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst) valid_o |=> !valid_o);
  a_r6_valid_after_done: assert property (@(posedge clk) disable iff (rst) valid_o |-> $past(done));
  // R7: the index moves only on an accepted strobe
  a_r7_k_hold: assert property (@(posedge clk) disable iff (rst) !$past(accept) |-> $stable(k));
  // R8: deselected channels read zero
  a_r8_sin_off_zero: assert property (@(posedge clk) disable iff (rst)
    valid_o && !ch_on[0] |-> sin_o == '0);
  a_r8_cos_off_zero: assert property (@(posedge clk) disable iff (rst)
    valid_o && !ch_on[1] |-> cos_o == '0);
  // R9: most negative code never produced
  a_r9_no_min_code: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> sin_o != {1'b1, {(OUT_W-1){1'b0}}} && cos_o != {1'b1, {(OUT_W-1){1'b0}}});

endmodule

// File: tb/sg_top_tb.sv
module sg_top_tb;
  localparam int  CLK_P = 10;
  localparam int  LAT   = 17;
  localparam int  TOL   = 6;
  localparam real PI    = 3.141592653589793;

  logic               clk = 1'b0, rst = 1'b1, smp_en = 1'b0;
  logic [15:0]        period = 16'd1;
  logic [16:0]        offset_h = '0;
  logic [1:0]         sel = 2'b11;
  logic signed [15:0] sin_o, cos_o;
  logic               valid_o;

  int n_chk = 0, n_err = 0;
  int cyc = 0, km = 0, busy_left = 0, p_m = 1, o2_m = 0, vcount = 0;
  logic [1:0] sel_m = 2'b11;
  bit first_pending = 1'b0, exp_v;
  string scen_tag = "";
  int due_q[$], num_q[$], k_q[$], first_q[$];

  always #(CLK_P/2) clk = ~clk;

  sg_top u_dut (
    .clk(clk), .rst(rst), .smp_en(smp_en), .period(period), .offset_h(offset_h),
    .sel(sel), .sin_o(sin_o), .cos_o(cos_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural model: accepts a strobe only when no sample is in flight
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      km = 0; busy_left = 0;
      due_q.delete(); num_q.delete(); k_q.delete(); first_q.delete();
    end else if (busy_left > 0) begin
      busy_left--;
    end else if (smp_en) begin
      due_q.push_back(cyc + LAT);
      num_q.push_back((2*km + o2_m) % (2*p_m));
      k_q.push_back(km);
      first_q.push_back(int'(first_pending));
      first_pending = 1'b0;
      km = (km + 1 == p_m) ? 0 : km + 1;
      busy_left = LAT - 1;
    end
  end

  task automatic check_chan(input int act, input int num, input int kk, input int first,
                            input bit cosine, input bit on);
    real r; int e; bit exact; string tag;
    if (!on) begin
      chk(act == 0, "R8", cosine ? "deselected cos" : "deselected sin", act, 0);
      return;
    end
    r = $sin(2.0*PI*(real'(num)/(2.0*p_m) + (cosine ? 0.25 : 0.0))) * 32767.0;
    e = $rtoi(r + ((r >= 0.0) ? 0.5 : -0.5));
    exact = ((num*4) % (2*p_m)) == 0;
    if (first != 0)          tag = "R1";
    else if (scen_tag != "") tag = scen_tag;
    else if (exact)          tag = "R9";
    else if (kk == 0)        tag = "R2";
    else                     tag = cosine ? "R4" : "R3";
    if (exact) chk(act == e, tag, cosine ? "cos exact" : "sin exact", act, e);
    else chk((act - e <= TOL) && (e - act <= TOL), tag, cosine ? "cos" : "sin", act, e);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
      chk(valid_o == exp_v, "R6", "valid timing", int'(valid_o), int'(exp_v));
      if (valid_o) vcount++;
      if (exp_v) begin
        void'(due_q.pop_front());
        check_chan(int'(sin_o), num_q[0], k_q[0], first_q[0], 1'b0, sel_m != 2'b10);
        check_chan(int'(cos_o), num_q[0], k_q[0], first_q[0], 1'b1, sel_m != 2'b01);
        void'(num_q.pop_front()); void'(k_q.pop_front()); void'(first_q.pop_front());
      end
    end
  end

  task automatic do_reset(input int p, input int o2, input logic [1:0] s);
    @(negedge clk);
    rst = 1'b1; smp_en = 1'b0;
    period = 16'(p); offset_h = 17'(o2); sel = s;
    p_m = p; o2_m = o2; sel_m = s; first_pending = 1'b1; scen_tag = "";
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R10", "valid in reset", int'(valid_o), 0);
    chk(sin_o == 0, "R10", "sin in reset", int'(sin_o), 0);
    chk(cos_o == 0, "R10", "cos in reset", int'(cos_o), 0);
    rst = 1'b0;
  endtask

  task automatic pulses(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); smp_en = 1'b1;
      @(negedge clk); smp_en = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic drain();
    repeat (LAT + 4) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // reference tone: p = 50, o = 12.5, both channels, strobe held high (R1, R2, R7, R9)
    do_reset(50, 25, 2'b11);
    vcount = 0;
    @(negedge clk); smp_en = 1'b1;
    repeat (LAT*60 - 1) @(negedge clk);
    smp_en = 1'b0;
    drain();
    chk(vcount == 60, "R7", "accepted samples with strobe held", vcount, 60);

    // short strobes spaced closer than the latency, half-sample offset, sine only (R5, R7, R8)
    do_reset(7, 13, 2'b01);
    scen_tag = "R5";
    vcount = 0;
    pulses(30, 4);
    drain();
    chk(vcount > 0 && vcount < 30, "R7", "strobes ignored while busy", vcount, 30);

    // configuration inputs changed after reset must be ignored (R10)
    scen_tag = "R10";
    period = 16'd3; offset_h = 17'd1; sel = 2'b10;
    pulses(10, 20);
    drain();

    // exact quarter points, cosine only (R8, R9)
    do_reset(4, 0, 2'b10);
    pulses(9, 18);
    drain();

    // period of one with half-sample offset, both via 2'b00 (R5, R8, R9)
    do_reset(1, 1, 2'b00);
    pulses(4, 18);
    drain();

    // long period, offset just below one period (R3, R4, R5)
    do_reset(1000, 1999, 2'b00);
    pulses(40, 19);
    drain();

    // non-power-of-two period with wrap checks on both channels (R2, R3, R4)
    do_reset(13, 6, 2'b11);
    pulses(30, 16);
    drain();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule